// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block connects a clocked requester to an external asynchronous static RAM of 131,072 sixteen-bit words. A request gives a word address, write data, a two-bit byte-lane mask and a direction flag. The controller turns each request into a correctly framed external cycle: strobes are active low, each byte lane has its own select, and the data bus is split into out, in and drive-enable signals. The number of wait cycles in each phase is fixed when the design is elaborated. It is computed from the clock period and the memory's access, write-pulse and bus-release times, always rounding up.

The request side follows a valid/ready handshake. The requester raises `req_valid` and holds the address, data, mask and direction unchanged until it sees `req_ready` high at a clock edge. `req_ready` is the completion acknowledge. It is high for exactly one clock per request, and no request is taken while a transfer or its bus-release recovery is still running. Back-pressure is therefore the length of the external cycle. For a read, `rd_data` is valid in the cycle where `req_ready` is high, and it keeps its value until the next read completes.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and while idle, all five strobes (`ce_n`, `oe_n`, `we_n`, `lb_n`, `ub_n`) are high, `dq_oe` is low and `req_ready` is low.
- R2: A read holds `ce_n` and `oe_n` low for RD_CYC cycles, where RD_CYC is the larger of ceil(T_AA_PS/CLK_PS) and ceil(T_OE_PS/CLK_PS) (4 by default). `req_ready` rises in the cycle after the last of them, so its latency is RD_CYC+1 clocks, counted from the accepting edge.
- R3: `rd_data[7:0]` carries the bus value only if mask bit 0 was set, and `rd_data[15:8]` only if mask bit 1 was set. A lane that was not selected reads as zero. `rd_data` holds its value through later writes until the next read completes.
- R4: A write sets up for one cycle with `ce_n` low and `we_n` high. It then holds `we_n` low for WP_CYC = ceil(T_WP_PS/CLK_PS) cycles (3 by default), then holds one cycle with `we_n` high. `req_ready` is high in that hold cycle, so the latency is WP_CYC+2 clocks. `we_n` is low only while `ce_n` is low.
- R5: `lb_n` is low only when mask bit 0 is set, and `ub_n` only when mask bit 1 is set, and in both cases only while `ce_n` is low. A write changes only the selected bytes in memory. A mask of 00 changes nothing.
- R6: The address never changes while `we_n` is low.
- R7: `dq_oe` is high only during the `we_n`-low cycles of a write and its hold cycle. It is never high while `oe_n` is low.
- R8: After `oe_n` rises at the end of a read, all strobes stay high and the bus stays undriven for REC_CYC = ceil(T_OHZ_PS/CLK_PS) cycles (2 by default, at least 1).
- R9: `req_ready` is high for exactly one cycle per request. A new request is accepted only from the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | One-cycle completion acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask, bit 0 = low byte, bit 1 = high byte |
| rd_data | output | 16 | Captured read data, unselected lanes zero |
| sram_addr | output | 17 | Memory address |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| lb_n | output | 1 | Low byte select, active low |
| ub_n | output | 1 | High byte select, active low |
| dq_out | output | 16 | Data driven toward memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 16 | Data returned by memory |

## Verification
A wrong state or wait count shows first as a wrong request-to-ready latency. That error appears on the very transaction where it happens, because every transfer is timed against RD_CYC+1 or WP_CYC+2. A wrong lane mask shows as stray bytes in `rd_data` or in memory on the next read-back of that address. The memory model in the bench returns a filler pattern on lanes that are not selected. A framing error, meaning the address moving under a low `we_n`, the bus driven during a read, or a recovery cut short, is caught in the same clock by the bench's per-cycle port monitor.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RREC  = 3'd2,
    ST_WSET  = 3'd3,
    ST_WLOW  = 3'd4,
    ST_WHOLD = 3'd5
  } asram_state_e;

  function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned maxu(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYC  = 4,
  parameter int unsigned REC_CYC = 2,
  parameter int unsigned WP_CYC  = 3,
  parameter int unsigned CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_zero,
  output asram_state_e  state,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          capture,
  output logic          ready
);
  localparam logic [CW-1:0] RD_LOAD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] REC_LOAD = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] WP_LOAD  = CW'(WP_CYC - 1);

  asram_state_e nxt;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    ready    = 1'b0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1;
        if (req_write) nxt = ST_WSET;
        else begin
          nxt      = ST_RD;
          tmr_load = 1'b1;
          tmr_val  = RD_LOAD;
        end
      end
      ST_RD: if (cnt_zero) begin
        capture  = 1'b1;
        nxt      = ST_RREC;
        tmr_load = 1'b1;
        tmr_val  = REC_LOAD;
      end
      ST_RREC: begin
        ready = (cnt == REC_LOAD);
        if (cnt_zero) nxt = ST_IDLE;
      end
      ST_WSET: begin
        nxt      = ST_WLOW;
        tmr_load = 1'b1;
        tmr_val  = WP_LOAD;
      end
      ST_WLOW: if (cnt_zero) nxt = ST_WHOLD;
      ST_WHOLD: begin
        ready = 1'b1;
        nxt   = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  AST_READY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R9
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> (state == ST_RD)); // R9
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  be_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)       rdata_q[g*8 +: 8] <= '0;
      else if (capture) rdata_q[g*8 +: 8] <= be_q[g] ? dq_in[g*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_PS    = 20000,
  parameter int unsigned T_AA_PS   = 70000,
  parameter int unsigned T_OE_PS   = 35000,
  parameter int unsigned T_WP_PS   = 50000,
  parameter int unsigned T_OHZ_PS  = 30000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              lb_n,
  output logic              ub_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned RD_CYC  = maxu(1, maxu(cdiv(T_AA_PS, CLK_PS), cdiv(T_OE_PS, CLK_PS)));
  localparam int unsigned REC_CYC = maxu(1, cdiv(T_OHZ_PS, CLK_PS));
  localparam int unsigned WP_CYC  = maxu(1, cdiv(T_WP_PS, CLK_PS));
  localparam int unsigned CW      = maxu(1, $clog2(maxu(RD_CYC, maxu(REC_CYC, WP_CYC)) + 1));

  asram_state_e    state;
  logic            tmr_load, tmr_zero, accept, capture;
  logic [CW-1:0]   tmr_val, tmr_cnt;
  logic [LANES-1:0] be_q;

  asram_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .cnt(tmr_cnt), .zero(tmr_zero)
  );

  asram_fsm #(.RD_CYC(RD_CYC), .REC_CYC(REC_CYC), .WP_CYC(WP_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .cnt(tmr_cnt), .cnt_zero(tmr_zero), .state(state), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .accept(accept), .capture(capture), .ready(req_ready)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be[LANES-1:0]),
    .dq_in(dq_in), .addr_q(sram_addr), .wdata_q(dq_out), .be_q(be_q),
    .rdata_q(rd_data)
  );

  logic chip_on;
  assign chip_on = (state == ST_RD) || (state == ST_WSET) ||
                   (state == ST_WLOW) || (state == ST_WHOLD);
  assign ce_n  = !chip_on;
  assign oe_n  = (state != ST_RD);
  assign we_n  = (state != ST_WLOW);
  assign lb_n  = !(chip_on && be_q[0]);
  assign ub_n  = !(chip_on && be_q[LANES-1]);
  assign dq_oe = (state == ST_WLOW) || (state == ST_WHOLD);

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> $stable(sram_addr)); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (ce_n && !dq_oe)); // R8
  AST_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_n || !ub_n) |-> !ce_n); // R5
  AST_CAPTURE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!oe_n && !ce_n)); // R2
endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;
  localparam int CLK_PS = 20000;
  localparam int RDC  = ((70000 + CLK_PS - 1) / CLK_PS > (35000 + CLK_PS - 1) / CLK_PS)
                        ? (70000 + CLK_PS - 1) / CLK_PS : (35000 + CLK_PS - 1) / CLK_PS;
  localparam int WPC  = (50000 + CLK_PS - 1) / CLK_PS;
  localparam int RECC = (30000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, ce_n, oe_n, we_n, lb_n, ub_n, dq_oe;
  logic [15:0] rd_data, dq_out, dq_in;
  logic [16:0] sram_addr;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  asram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rd_data(rd_data), .sram_addr(sram_addr), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  // memory model: 1024 words indexed by {addr[16], addr[8:0]}
  logic [15:0] mem [0:1023];
  logic [15:0] shadow [0:1023];
  function automatic int idx(input logic [16:0] a);
    return int'({a[16], a[8:0]});
  endfunction

  logic [15:0] cur;
  assign cur   = mem[idx(sram_addr)];
  assign dq_in = (!ce_n && !oe_n) ? {(!ub_n ? cur[15:8] : 8'hA5), (!lb_n ? cur[7:0] : 8'hA5)}
                                  : 16'hC3C3;

  int viol_r6 = 0, viol_r7 = 0, viol_r8 = 0, viol_r4 = 0;
  always @(posedge we_n) begin
    if (rst_n && !ce_n) begin
      if (!dq_oe) viol_r4++;
      if (!lb_n) mem[idx(sram_addr)][7:0]  = dq_out[7:0];
      if (!ub_n) mem[idx(sram_addr)][15:8] = dq_out[15:8];
    end
  end

  logic [16:0] prev_addr = '0;
  logic prev_oe_n = 1'b1;
  int since_oe = 100;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n && sram_addr != prev_addr) viol_r6++;
      if (!we_n && ce_n) viol_r4++;
      if (dq_oe && !oe_n) viol_r7++;
      if (!prev_oe_n && oe_n) since_oe = 0;
      else if (since_oe < 100) since_oe++;
      if (since_oe < RECC && (dq_oe || !ce_n)) viol_r8++;
    end
    prev_addr = sram_addr;
    prev_oe_n = oe_n;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [16:0] a, input logic [15:0] d,
                      input logic [1:0] b, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = b;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!req_ready && lat < 40);
    rd = rd_data;
    @(negedge clk);
    chk(!req_ready, "R9", longint'(req_ready), 0);
    req_valid = 1'b0;
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] rd, hold;
    int lat;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 16'((i * 40503 + 7) & 16'hFFFF);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset/idle state
    chk({ce_n, oe_n, we_n, lb_n, ub_n} == 5'b11111, "R1",
        longint'({ce_n, oe_n, we_n, lb_n, ub_n}), 5'h1F);
    chk(!dq_oe && !req_ready, "R1", longint'({dq_oe, req_ready}), 0);

    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 6; k++) begin
        logic [16:0] a;
        logic [15:0] d, m, e;
        a = {k[0], 7'd0, 9'((k * 61 + b * 13) & 9'h1FF)};
        d = 16'((k * 4099 + b * 771 + 16'h1234) & 16'hFFFF);
        m = lane_mask(2'(b));
        // write with mask b (R4, R5)
        xfer(1'b1, a, d, 2'(b), rd, lat);
        chk(lat == WPC + 2, "R4", lat, WPC + 2);
        shadow[idx(a)] = (shadow[idx(a)] & ~m) | (d & m);
        // full read-back: only selected bytes changed (R5), latency (R2)
        xfer(1'b0, a, 16'h0, 2'b11, rd, lat);
        chk(lat == RDC + 1, "R2", lat, RDC + 1);
        chk(rd == shadow[idx(a)], "R5", rd, shadow[idx(a)]);
        // partial read: unselected lanes zero (R3)
        xfer(1'b0, a, 16'h0, 2'(b), rd, lat);
        e = shadow[idx(a)] & m;
        chk(rd == e, "R3", rd, e);
        // rd_data holds across a following write (R3)
        hold = rd_data;
        xfer(1'b1, a ^ 17'h100, 16'h0F0F, 2'b00, rd, lat);
        chk(rd_data == hold, "R3", rd_data, hold);
      end
    end
    // back-to-back read then write, idle afterwards (R1, R8)
    xfer(1'b0, 17'h00005, 16'h0, 2'b01, rd, lat);
    xfer(1'b1, 17'h00005, 16'hBEEF, 2'b11, rd, lat);
    shadow[idx(17'h5)] = 16'hBEEF;
    xfer(1'b0, 17'h00005, 16'h0, 2'b11, rd, lat);
    chk(rd == 16'hBEEF, "R8", rd, 16'hBEEF);
    @(negedge clk);
    @(negedge clk);
    chk({ce_n, oe_n, we_n, lb_n, ub_n, dq_oe} == 6'b111110, "R1",
        longint'({ce_n, oe_n, we_n, lb_n, ub_n, dq_oe}), 6'h3E);
    chk(viol_r6 == 0, "R6", viol_r6, 0);
    chk(viol_r7 == 0, "R7", viol_r7, 0);
    chk(viol_r8 == 0, "R8", viol_r8, 0);
    chk(viol_r4 == 0, "R4", viol_r4, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule